// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Event Line Controller

This block watches a bank of asynchronous request lines. Each line passes through a two-flop synchroniser, and the block then looks for a rising edge, a falling edge or both, as chosen per line. A qualifying edge latches a pending flag when the line's interrupt mask bit is set. Pending flags stay set until software clears them by writing 1. Each line has its own interrupt output, which is its pending flag gated by its mask bit. A single combined request is the OR of all those outputs. A line whose event mask bit is set also gives a one-cycle event pulse on each trigger, whatever its pending state.

Software drives the block through a single-cycle register port. Writes take effect at the clock edge and reads are combinational. Software can raise a line itself through the software-trigger register. A trigger bit stays set until its pending flag is cleared. An edge that is detected in the same cycle as a write to the matching edge-select register is lost.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, the event mask, rising-select, falling-select, software-trigger and pending registers read 0. The interrupt mask reads the `RST_IRQ_MASK` parameter, and every output is low.
- R2: A low-to-high change on a line whose rising-select bit is 1 and whose mask bit is 1 sets that line's pending bit. The change is made before clock edge k, the bit is still 0 after edge k+1 and reads 1 after edge k+2. A high-to-low change on a line with only rising-select set does nothing.
- R3: A falling-select bit makes high-to-low changes trigger. With both selects set, either direction triggers. With neither set, no change triggers.
- R4: An edge on a line whose interrupt mask bit is 0 never sets its pending bit.
- R5: Writing the pending register clears each bit written as 1 and leaves each bit written as 0 unchanged. A trigger in the same cycle as the clear of that bit leaves the bit set.
- R6: `irq_line` is the pending register ANDed with the interrupt mask, and `irq_any` is the OR of `irq_line`. Clearing a mask bit hides the output but keeps the pending bit.
- R7: A trigger on a line whose event mask bit is 1 drives `evt_pulse` for that line high for one cycle. The pulse rises at the same edge at which the pending bit would be set, whatever the interrupt mask says.
- R8: Writing 1 to a software-trigger bit that reads 0 sets that bit, and also sets the pending bit at the same edge when the line is unmasked. Writing 1 to a software-trigger bit that already reads 1 does not trigger.
- R9: A software-trigger bit stays 1 until software writes 1 to the same bit of the pending register, which clears both bits.
- R10: A rising edge that is detected in the same cycle as any write to the rising-select register is dropped. The same holds for a falling edge and a write to the falling-select register.
- R11: The register offsets are: interrupt mask 0x00, event mask 0x04, rising-select 0x08, falling-select 0x0C, software-trigger 0x10 and pending 0x14. Bit n of each register belongs to line n. Any other address, including one with nonzero low two bits, reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | N_LINES | Asynchronous request lines |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 5 | Byte address of the register |
| reg_wdata | input | N_LINES | Write data |
| reg_rdata | output | N_LINES | Combinational read data for `reg_addr` |
| irq_line | output | N_LINES | Per-line interrupt request |
| irq_any | output | 1 | OR of all per-line requests |
| evt_pulse | output | N_LINES | One-cycle event pulse per line |

## Verification
The hardest condition to reach from the ports is the write collision. The register write has to land in the one cycle in which the synchronised edge is visible to the detector, and that cycle lies two clock edges after the pin changes. The bench counts the synchroniser stages, presents the edge-select write one cycle after the pin change, and expects the pending bit to stay 0. It then uses the same alignment with a pending clear, to show that a trigger beats the clear of its own bit.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int ADDR_W = 5;

  typedef enum logic [2:0] {
    SEL_IRQ_MASK = 3'd0,
    SEL_EVT_MASK = 3'd1,
    SEL_RISE     = 3'd2,
    SEL_FALL     = 3'd3,
    SEL_SWT      = 3'd4,
    SEL_PEND     = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic irq_mask;
    logic evt_mask;
    logic rise;
    logic fall;
    logic swt;
    logic pend;
  } wr_strobe_t;
endpackage

// File: rtl/eic_edge_detect.sv
module eic_edge_detect #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_in,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= line_in[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign rise_o[g] = sync_q & ~prev_q;
    assign fall_o[g] = ~sync_q & prev_q;
  end
endmodule

// File: rtl/eic_cfg_regs.sv
module eic_cfg_regs
  import eic_pkg::*;
#(
  parameter int           N            = 32,
  parameter logic [N-1:0] RST_IRQ_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  wr_strobe_t   wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] irq_mask_q,
  output logic [N-1:0] evt_mask_q,
  output logic [N-1:0] rise_sel_q,
  output logic [N-1:0] fall_sel_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_mask_q <= RST_IRQ_MASK;
      evt_mask_q <= '0;
      rise_sel_q <= '0;
      fall_sel_q <= '0;
    end else begin
      if (wr.irq_mask) irq_mask_q <= wdata;
      if (wr.evt_mask) evt_mask_q <= wdata;
      if (wr.rise)     rise_sel_q <= wdata;
      if (wr.fall)     fall_sel_q <= wdata;
    end
  end
endmodule

// File: rtl/eic_pend_unit.sv
module eic_pend_unit
  import eic_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rise_det,
  input  logic [N-1:0] fall_det,
  input  logic [N-1:0] irq_mask,
  input  logic [N-1:0] evt_mask,
  input  logic [N-1:0] rise_sel,
  input  logic [N-1:0] fall_sel,
  input  wr_strobe_t   wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] swt_q,
  output logic [N-1:0] evt_q
);
  logic [N-1:0] hw_hit, sw_hit, trig, clr;

  always_comb begin
    // an edge seen while its select register is being written is discarded
    hw_hit = (rise_det & rise_sel & {N{~wr.rise}})
           | (fall_det & fall_sel & {N{~wr.fall}});
    sw_hit = wr.swt  ? (wdata & ~swt_q) : '0;
    clr    = wr.pend ? wdata : '0;
    trig   = hw_hit | sw_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      swt_q  <= '0;
      evt_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~clr) | (trig & irq_mask);
      swt_q  <= (swt_q & ~clr) | sw_hit;
      evt_q  <= trig & evt_mask;
    end
  end
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import eic_pkg::*;
#(
  parameter int                 N_LINES      = 32,
  parameter logic [N_LINES-1:0] RST_IRQ_MASK = 32'h00C0_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_LINES-1:0]   line_in,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [N_LINES-1:0]   reg_wdata,
  output logic [N_LINES-1:0]   reg_rdata,
  output logic [N_LINES-1:0]   irq_line,
  output logic                 irq_any,
  output logic [N_LINES-1:0]   evt_pulse
);
  logic              aligned;
  logic [2:0]        sel;
  wr_strobe_t        wr;
  logic [N_LINES-1:0] rise_det, fall_det;
  logic [N_LINES-1:0] irq_mask_q, evt_mask_q, rise_sel_q, fall_sel_q;
  logic [N_LINES-1:0] pend_q, swt_q;

  assign aligned = (reg_addr[1:0] == 2'b00);
  assign sel     = reg_addr[ADDR_W-1:2];

  always_comb begin
    wr.irq_mask = reg_we && aligned && (sel == SEL_IRQ_MASK);
    wr.evt_mask = reg_we && aligned && (sel == SEL_EVT_MASK);
    wr.rise     = reg_we && aligned && (sel == SEL_RISE);
    wr.fall     = reg_we && aligned && (sel == SEL_FALL);
    wr.swt      = reg_we && aligned && (sel == SEL_SWT);
    wr.pend     = reg_we && aligned && (sel == SEL_PEND);
  end

  eic_edge_detect #(.N(N_LINES)) u_edge (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .rise_o(rise_det), .fall_o(fall_det)
  );

  eic_cfg_regs #(.N(N_LINES), .RST_IRQ_MASK(RST_IRQ_MASK)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(wr), .wdata(reg_wdata),
    .irq_mask_q(irq_mask_q), .evt_mask_q(evt_mask_q),
    .rise_sel_q(rise_sel_q), .fall_sel_q(fall_sel_q)
  );

  eic_pend_unit #(.N(N_LINES)) u_pend (
    .clk(clk), .rst_n(rst_n), .rise_det(rise_det), .fall_det(fall_det),
    .irq_mask(irq_mask_q), .evt_mask(evt_mask_q),
    .rise_sel(rise_sel_q), .fall_sel(fall_sel_q),
    .wr(wr), .wdata(reg_wdata),
    .pend_q(pend_q), .swt_q(swt_q), .evt_q(evt_pulse)
  );

  always_comb begin
    reg_rdata = '0;
    if (aligned) begin
      case (sel)
        SEL_IRQ_MASK: reg_rdata = irq_mask_q;
        SEL_EVT_MASK: reg_rdata = evt_mask_q;
        SEL_RISE:     reg_rdata = rise_sel_q;
        SEL_FALL:     reg_rdata = fall_sel_q;
        SEL_SWT:      reg_rdata = swt_q;
        SEL_PEND:     reg_rdata = pend_q;
        default:      reg_rdata = '0;
      endcase
    end
  end

  assign irq_line = pend_q & irq_mask_q;
  assign irq_any  = |irq_line;
endmodule

// File: rtl/eic_checker.sv
module eic_checker #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_we,
  input logic [4:0]   reg_addr,
  input logic [N-1:0] reg_wdata,
  input logic [N-1:0] pend,
  input logic [N-1:0] swt,
  input logic [N-1:0] irq_mask,
  input logic [N-1:0] evt_mask,
  input logic [N-1:0] evt_pulse
);
  logic [N-1:0] clr_req;
  assign clr_req = (reg_we && reg_addr == 5'h14) ? reg_wdata : '0;

  // R4: a pending bit only appears on a line that was unmasked
  assert_mask_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(pend) & ~$past(irq_mask)) == '0);

  // R5: a pending bit only drops after a write of 1 to it
  assert_w1c_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend) & ~pend & ~$past(clr_req)) == '0);

  // R7: event pulses only on lines whose event mask was set
  assert_evt_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse & ~$past(evt_mask)) == '0);

  // R9: a software-trigger bit only drops with a pending clear
  assert_swt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(swt) & ~swt & ~$past(clr_req)) == '0);
endmodule

bind edge_irq_ctrl eic_checker #(.N(N_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .pend(pend_q), .swt(swt_q),
  .irq_mask(irq_mask_q), .evt_mask(evt_mask_q), .evt_pulse(evt_pulse)
);

// File: tb/edge_irq_ctrl_tb.sv
module edge_irq_ctrl_tb;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] DIRECT     = 32'h00C0_0000;
  localparam logic [4:0]  A_MASK = 5'h00, A_EVT = 5'h04, A_RISE = 5'h08,
                          A_FALL = 5'h0C, A_SWT = 5'h10, A_PEND = 5'h14;

  typedef struct packed {
    logic [4:0] ln;
    logic rise; logic fall; logic msk; logic emr; logic up;
    logic exp_p; logic exp_e;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{5'd3,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R2 rise
    '{5'd3,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 fall ignored
    '{5'd7,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 fall
    '{5'd7,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R3 both, up
    '{5'd7,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 both, down
    '{5'd12, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 none
    '{5'd20, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}, // R4/R7 masked, event
    '{5'd31, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}  // R7 both outputs
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] line_in;
  logic        reg_we;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, irq_line, evt_pulse;
  logic        irq_any;
  int          n_checks = 0;
  int          n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_irq_ctrl #(.N_LINES(32), .RST_IRQ_MASK(DIRECT)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_line(irq_line), .irq_any(irq_any), .evt_pulse(evt_pulse)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic bus_read(logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle_clear();
    repeat (4) @(negedge clk);
    bus_write(A_PEND, 32'hFFFF_FFFF);
  endtask

  task automatic run_all();
    logic [31:0] rd;
    // reset state, R1
    rst_n = 1'b0; line_in = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(A_MASK, rd); chk("R1", "irq mask reset", rd, DIRECT);
    bus_read(A_EVT,  rd); chk("R1", "evt mask reset", rd, 32'h0);
    bus_read(A_RISE, rd); chk("R1", "rise reset", rd, 32'h0);
    bus_read(A_FALL, rd); chk("R1", "fall reset", rd, 32'h0);
    bus_read(A_SWT,  rd); chk("R1", "swt reset", rd, 32'h0);
    bus_read(A_PEND, rd); chk("R1", "pend reset", rd, 32'h0);
    chk("R1", "irq_any reset", {31'h0, irq_any}, 32'h0);
    chk("R1", "evt reset", evt_pulse, 32'h0);

    // table walk: R2 R3 R4 R6 R7
    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      logic [31:0] bit_m = 32'h1 << v.ln;
      bus_write(A_MASK, v.msk  ? bit_m : 32'h0);
      bus_write(A_EVT,  v.emr  ? bit_m : 32'h0);
      bus_write(A_RISE, v.rise ? bit_m : 32'h0);
      bus_write(A_FALL, v.fall ? bit_m : 32'h0);
      line_in[v.ln] = ~v.up;
      settle_clear();
      line_in[v.ln] = v.up;
      repeat (2) @(negedge clk);
      bus_read(A_PEND, rd); chk("R2", "pend before 3rd edge", rd, 32'h0);
      @(negedge clk);
      bus_read(A_PEND, rd);
      chk("R2/R3/R4", "pend after edge", rd, v.exp_p ? bit_m : 32'h0);
      chk("R7", "evt pulse", evt_pulse, v.exp_e ? bit_m : 32'h0);
      chk("R6", "irq_line", irq_line, (v.exp_p && v.msk) ? bit_m : 32'h0);
      @(negedge clk);
      chk("R7", "evt one cycle", evt_pulse, 32'h0);
      bus_write(A_PEND, 32'hFFFF_FFFF);
    end

    // R5 write-1-to-clear on line 3
    bus_write(A_MASK, 32'h8); bus_write(A_EVT, 32'h0);
    bus_write(A_RISE, 32'h8); bus_write(A_FALL, 32'h0);
    line_in[3] = 1'b0; settle_clear();
    line_in[3] = 1'b1; repeat (3) @(negedge clk);
    bus_write(A_PEND, ~32'h8);
    bus_read(A_PEND, rd); chk("R5", "zero write keeps", rd, 32'h8);
    // R6 mask hides output, pending kept
    chk("R6", "irq_any set", {31'h0, irq_any}, 32'h1);
    bus_write(A_MASK, 32'h0);
    chk("R6", "irq_any masked", {31'h0, irq_any}, 32'h0);
    chk("R6", "irq_line masked", irq_line, 32'h0);
    bus_read(A_PEND, rd); chk("R6", "pend kept", rd, 32'h8);
    bus_write(A_MASK, 32'h8);
    chk("R6", "irq_line back", irq_line, 32'h8);
    bus_write(A_PEND, 32'h8);
    bus_read(A_PEND, rd); chk("R5", "one write clears", rd, 32'h0);

    // R5 trigger beats clear in the same cycle
    line_in[3] = 1'b0; settle_clear();
    line_in[3] = 1'b1; @(negedge clk);
    bus_write(A_PEND, 32'h8);
    bus_read(A_PEND, rd); chk("R5", "set wins over clear", rd, 32'h8);
    bus_write(A_PEND, 32'h8);

    // R10 collision with rise-select write
    line_in[3] = 1'b0; settle_clear();
    line_in[3] = 1'b1; @(negedge clk);
    bus_write(A_RISE, 32'h8);
    repeat (2) @(negedge clk);
    bus_read(A_PEND, rd); chk("R10", "rise dropped", rd, 32'h0);
    // R10 collision with fall-select write
    bus_write(A_FALL, 32'h8);
    settle_clear();
    line_in[3] = 1'b0; @(negedge clk);
    bus_write(A_FALL, 32'h8);
    repeat (2) @(negedge clk);
    bus_read(A_PEND, rd); chk("R10", "fall dropped", rd, 32'h0);

    // R8 R9 software trigger on line 5
    bus_write(A_MASK, 32'h20);
    bus_write(A_SWT, 32'h20);
    bus_read(A_PEND, rd); chk("R8", "sw sets pend", rd, 32'h20);
    bus_read(A_SWT, rd);  chk("R8", "sw bit set", rd, 32'h20);
    chk("R8", "sw irq_any", {31'h0, irq_any}, 32'h1);
    bus_write(A_PEND, 32'h0);
    bus_read(A_SWT, rd);  chk("R9", "sw bit holds", rd, 32'h20);
    bus_write(A_PEND, 32'h20);
    bus_read(A_SWT, rd);  chk("R9", "sw bit cleared", rd, 32'h0);
    bus_read(A_PEND, rd); chk("R9", "pend cleared", rd, 32'h0);
    // R8 masked then repeat write while already set
    bus_write(A_MASK, 32'h0);
    bus_write(A_SWT, 32'h200);
    bus_read(A_PEND, rd); chk("R8", "masked sw no pend", rd, 32'h0);
    bus_write(A_MASK, 32'h200);
    bus_write(A_SWT, 32'h200);
    bus_read(A_PEND, rd); chk("R8", "already-set no trigger", rd, 32'h0);
    bus_write(A_PEND, 32'h200);
    bus_read(A_SWT, rd);  chk("R9", "clear drops sw bit", rd, 32'h0);
    bus_write(A_SWT, 32'h200);
    bus_read(A_PEND, rd); chk("R8", "rearmed sw triggers", rd, 32'h200);
    bus_write(A_PEND, 32'hFFFF_FFFF);

    // R11 map and unused addresses
    bus_write(A_EVT, 32'hA5A5_0000);
    bus_read(A_EVT, rd);  chk("R11", "evt readback", rd, 32'hA5A5_0000);
    bus_write(A_FALL, 32'h0000_5A5A);
    bus_read(A_FALL, rd); chk("R11", "fall readback", rd, 32'h0000_5A5A);
    bus_write(5'h18, 32'hFFFF_FFFF);
    bus_read(5'h18, rd);  chk("R11", "unused reads 0", rd, 32'h0);
    bus_write(5'h01, 32'hFFFF_FFFF);
    bus_read(A_MASK, rd); chk("R11", "misaligned write ignored", rd, 32'h200);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule